// File: doc/BRIEF.md
# Fused-Layer Tile Sequencer with Tile Concatenation

This control block drives tile-by-tile inference through a deep stack of fused layers. For each step it presents one command to a compute engine: the tile number, the layer index, which of three activation banks to read, which to write, whether to add a held skip operand, and what the side tile memory should do. It holds the command until the engine pulses done, then moves to the next step. A tile runs through every configured layer before the next input tile starts.

Activations stay in the banks from one layer to the next. The bank written by one layer is read in place by the following layer. A residual fork pins its input bank as a hold bank, so the skip operand survives while the other two banks alternate. The pin is released at the matching add layer. Up to three concatenation layers can be configured. At each one, the first arrival parks the finished tile in a tile-memory slot and restarts the next input tile from layer 0. The second arrival merges the parked half back in and carries on deeper. Nested concatenation points therefore form a binary recursion over the input tiles.

Top module: `tile_seq`

## Requirements
- R1: Within one tile, `cmd_layer` steps 0, 1, 2, … by one on each done pulse. A new tile id appears only with `cmd_layer` = 0, and only after the done of the final layer or of a store layer. Tile ids start at 0 and increase by one.
- R2: Banks are coded 0, 1 and 2, and `cmd_in_bank` is never equal to `cmd_out_bank`. The output bank is the lowest-numbered bank that is neither the input bank nor a currently held bank.
- R3: After the done of a layer that does not cause a restart, the next command's input bank equals the previous command's output bank.
- R4: A fork flag on layer n, when no bank is held, makes layer n's input bank the held bank once that layer completes. A held bank is never an input or output bank. A join flag on layer m while a bank is held sets `cmd_skip_use` = 1 with `cmd_skip_bank` = held bank, and releases the hold after layer m completes. A fork while a bank is held is ignored, and so is a join when no bank is held.
- R5: `cmd_tm_op` uses 0 for none, 1 for store and 2 for merge, and never 3. On an enabled concatenation slot j whose layer equals `cmd_layer`, the command carries store if slot j has no parked tile and merge if it has one, with `cmd_tm_slot` = j. If two enabled slots name the same layer, the lower-numbered slot wins.
- R6: After a store command completes, the next command has tile id + 1, layer 0 and input bank 0, and any hold is released.
- R7: After a merge command completes, the sequencer continues at the next layer with the banks rotating as in R3, and the slot no longer holds a parked tile.
- R8: Concatenation slots keep independent parked state, so with three nested slots each final pass consumes eight input tiles.
- R9: While no done pulse arrives, `cmd_valid` stays high and every command field stays stable. A done pulse while idle has no effect.
- R10: `start` is accepted only while idle, with 1 ≤ `cfg_layers` ≤ MAX_LAYERS and `cfg_tiles` ≥ 1. The first command is tile 0, layer 0, input bank 0. A start while busy, or with an invalid configuration, changes nothing.
- R11: `busy` (equal to `cmd_valid`) rises after an accepted start. It falls on the done of the final layer when the tile id is at least `cfg_tiles` − 1.
- R12: After reset, `busy` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; latches the configuration |
| cfg_layers | input | 5 | Number of fused layers |
| cfg_tiles | input | 8 | Number of input tiles |
| cfg_cat_layers | input | 12 | Concatenation layer per slot, 4 bits each, slot j at bits [4j+3:4j] |
| cfg_cat_en | input | 3 | Enable per concatenation slot |
| cfg_fork_mask | input | 16 | Bit n: layer n forks a residual |
| cfg_join_mask | input | 16 | Bit n: layer n adds the held residual |
| eng_done | input | 1 | Compute engine finished the current command |
| busy | output | 1 | Sequence in progress |
| cmd_valid | output | 1 | Command present |
| cmd_tile | output | 8 | Tile id |
| cmd_layer | output | 4 | Layer index |
| cmd_in_bank | output | 2 | Bank to read |
| cmd_out_bank | output | 2 | Bank to write |
| cmd_skip_bank | output | 2 | Held residual bank |
| cmd_skip_use | output | 1 | Add the held residual on this layer |
| cmd_tm_op | output | 2 | Tile-memory operation |
| cmd_tm_slot | output | 2 | Tile-memory slot |

## Verification
The bench builds the block with its default parameters: a 16-layer limit, 8-bit tile ids and three concatenation slots. These values allow the full-depth stack and a triple-nested concatenation that consumes eight input tiles per pass. The same settings cover two slots naming one layer, residual holds that a store restart cuts off, and single-layer networks. A scoreboard model predicts every command tuple under several engine latencies, including a start that is rejected mid-run.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    localparam int NBANK = 3;

    typedef logic [1:0] bank_t;

    typedef enum logic [1:0] {
        TM_NONE  = 2'd0,
        TM_STORE = 2'd1,
        TM_MERGE = 2'd2
    } tm_op_e;

    typedef struct packed {
        bank_t in_bank;
        bank_t hold_bank;
        logic  hold_act;
    } rot_t;

    localparam rot_t ROT_FRESH = '{in_bank: 2'd0, hold_bank: 2'd0, hold_act: 1'b0};

    // lowest bank that is neither the reader nor the pinned one
    function automatic bank_t free_bank(bank_t rd, bank_t pin, logic pin_ok);
        bank_t r;
        r = 2'd0;
        for (int k = NBANK - 1; k >= 0; k--) begin
            if (bank_t'(k) != rd && !(pin_ok && bank_t'(k) == pin))
                r = bank_t'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/tseq_bank_rot.sv
module tseq_bank_rot
    import tseq_pkg::*;
(
    input  rot_t  cur,
    input  logic  fork_en,
    input  logic  join_en,
    output bank_t out_bank,
    output logic  skip_use,
    output rot_t  nxt
);
    always_comb begin
        out_bank = free_bank(cur.in_bank, cur.hold_bank, cur.hold_act);
        skip_use = join_en && cur.hold_act;
        nxt          = cur;
        nxt.in_bank  = out_bank;
        if (skip_use) begin
            nxt.hold_act = 1'b0;
        end else if (fork_en && !cur.hold_act) begin
            nxt.hold_act  = 1'b1;
            nxt.hold_bank = cur.in_bank;
        end
    end
endmodule

// File: rtl/tseq_cat_track.sv
module tseq_cat_track
    import tseq_pkg::*;
#(
    parameter int NCAT = 3,
    parameter int LW   = 4,
    parameter int SW   = 2
) (
    input  logic [LW-1:0]      layer,
    input  logic [NCAT*LW-1:0] cat_layers,
    input  logic [NCAT-1:0]    cat_en,
    input  logic [NCAT-1:0]    pend,
    output tm_op_e             op,
    output logic [SW-1:0]      slot
);
    logic [NCAT-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NCAT; g++) begin : g_hit
            assign hit[g] = cat_en[g] && (cat_layers[g*LW +: LW] == layer);
        end
    endgenerate

    always_comb begin
        op   = TM_NONE;
        slot = '0;
        for (int j = NCAT - 1; j >= 0; j--) begin
            if (hit[j]) begin
                op   = pend[j] ? TM_MERGE : TM_STORE;
                slot = SW'(j);
            end
        end
    end
endmodule

// File: rtl/tile_seq.sv
module tile_seq
    import tseq_pkg::*;
#(
    parameter int MAX_LAYERS = 16,
    parameter int TILE_W     = 8,
    parameter int NUM_CAT    = 3,
    localparam int LW = $clog2(MAX_LAYERS),
    localparam int CW = LW + 1,
    localparam int SW = (NUM_CAT > 1) ? $clog2(NUM_CAT) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [CW-1:0]         cfg_layers,
    input  logic [TILE_W-1:0]     cfg_tiles,
    input  logic [NUM_CAT*LW-1:0] cfg_cat_layers,
    input  logic [NUM_CAT-1:0]    cfg_cat_en,
    input  logic [MAX_LAYERS-1:0] cfg_fork_mask,
    input  logic [MAX_LAYERS-1:0] cfg_join_mask,
    input  logic                  eng_done,
    output logic                  busy,
    output logic                  cmd_valid,
    output logic [TILE_W-1:0]     cmd_tile,
    output logic [LW-1:0]         cmd_layer,
    output logic [1:0]            cmd_in_bank,
    output logic [1:0]            cmd_out_bank,
    output logic [1:0]            cmd_skip_bank,
    output logic                  cmd_skip_use,
    output logic [1:0]            cmd_tm_op,
    output logic [SW-1:0]         cmd_tm_slot
);
    // latched configuration
    logic [CW-1:0]         r_layers;
    logic [TILE_W-1:0]     r_tiles;
    logic [NUM_CAT*LW-1:0] r_cat_layers;
    logic [NUM_CAT-1:0]    r_cat_en;
    logic [MAX_LAYERS-1:0] r_fork;
    logic [MAX_LAYERS-1:0] r_join;

    // sequencing state
    logic                  busy_q;
    logic [LW-1:0]         layer_q;
    logic [TILE_W-1:0]     tile_q;
    rot_t                  rot_q;
    logic [NUM_CAT-1:0]    pend_q;

    rot_t          rot_nxt;
    bank_t         out_bank;
    logic          skip_use;
    tm_op_e        tm_op;
    logic [SW-1:0] tm_slot;
    logic          cfg_ok;
    logic          last_layer;
    logic          last_tile;

    tseq_bank_rot u_rot (
        .cur      (rot_q),
        .fork_en  (r_fork[layer_q]),
        .join_en  (r_join[layer_q]),
        .out_bank (out_bank),
        .skip_use (skip_use),
        .nxt      (rot_nxt)
    );

    tseq_cat_track #(.NCAT(NUM_CAT), .LW(LW), .SW(SW)) u_cat (
        .layer      (layer_q),
        .cat_layers (r_cat_layers),
        .cat_en     (r_cat_en),
        .pend       (pend_q),
        .op         (tm_op),
        .slot       (tm_slot)
    );

    assign cfg_ok     = (cfg_layers != '0) && (cfg_layers <= CW'(MAX_LAYERS)) && (cfg_tiles != '0);
    assign last_layer = ({1'b0, layer_q} == r_layers - CW'(1));
    assign last_tile  = (tile_q >= r_tiles - TILE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            layer_q      <= '0;
            tile_q       <= '0;
            rot_q        <= ROT_FRESH;
            pend_q       <= '0;
            r_layers     <= '0;
            r_tiles      <= '0;
            r_cat_layers <= '0;
            r_cat_en     <= '0;
            r_fork       <= '0;
            r_join       <= '0;
        end else if (!busy_q) begin
            if (start && cfg_ok) begin
                r_layers     <= cfg_layers;
                r_tiles      <= cfg_tiles;
                r_cat_layers <= cfg_cat_layers;
                r_cat_en     <= cfg_cat_en;
                r_fork       <= cfg_fork_mask;
                r_join       <= cfg_join_mask;
                busy_q       <= 1'b1;
                layer_q      <= '0;
                tile_q       <= '0;
                rot_q        <= ROT_FRESH;
                pend_q       <= '0;
            end
        end else if (eng_done) begin
            if (tm_op == TM_STORE) begin
                // park this half, replay the neighbour from the first layer
                pend_q[tm_slot] <= 1'b1;
                tile_q          <= tile_q + TILE_W'(1);
                layer_q         <= '0;
                rot_q           <= ROT_FRESH;
            end else if (last_layer) begin
                if (last_tile) begin
                    busy_q <= 1'b0;
                end else begin
                    tile_q  <= tile_q + TILE_W'(1);
                    layer_q <= '0;
                    rot_q   <= ROT_FRESH;
                    pend_q  <= '0;
                end
            end else begin
                if (tm_op == TM_MERGE)
                    pend_q[tm_slot] <= 1'b0;
                layer_q <= layer_q + LW'(1);
                rot_q   <= rot_nxt;
            end
        end
    end

    assign busy          = busy_q;
    assign cmd_valid     = busy_q;
    assign cmd_tile      = tile_q;
    assign cmd_layer     = layer_q;
    assign cmd_in_bank   = rot_q.in_bank;
    assign cmd_out_bank  = out_bank;
    assign cmd_skip_bank = rot_q.hold_bank;
    assign cmd_skip_use  = skip_use;
    assign cmd_tm_op     = tm_op;
    assign cmd_tm_slot   = tm_slot;
endmodule

// File: rtl/tseq_chk.sv
module tseq_chk #(
    parameter int LW = 4,
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          cmd_valid,
    input logic [TW-1:0] cmd_tile,
    input logic [LW-1:0] cmd_layer,
    input logic [1:0]    cmd_in_bank,
    input logic [1:0]    cmd_out_bank,
    input logic [1:0]    cmd_skip_bank,
    input logic          cmd_skip_use,
    input logic [1:0]    cmd_tm_op,
    input logic          eng_done
);
    AST_BANK_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_in_bank != cmd_out_bank) && (cmd_in_bank != 2'd3) && (cmd_out_bank != 2'd3)); // R2

    AST_OUT_FEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(cmd_valid && eng_done) && cmd_layer != '0)
        |-> cmd_in_bank == $past(cmd_out_bank)); // R3

    AST_SKIP_APART: assert property (@(posedge clk) disable iff (rst)
        cmd_skip_use |-> (cmd_skip_bank != cmd_in_bank) && (cmd_skip_bank != cmd_out_bank)); // R4

    AST_TM_CODE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_tm_op != 2'd3); // R5

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && !eng_done)
        |-> cmd_valid && $stable(cmd_layer) && $stable(cmd_tile) && $stable(cmd_in_bank)); // R9

    AST_SAME_TILE_DEEP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(cmd_valid) && cmd_layer != '0) |-> cmd_tile == $past(cmd_tile)); // R1

    AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cmd_layer == '0) && (cmd_tile == '0) && (cmd_in_bank == 2'd0)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_valid == busy); // R11
endmodule

bind tile_seq tseq_chk #(.LW(LW), .TW(TILE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .cmd_valid     (cmd_valid),
    .cmd_tile      (cmd_tile),
    .cmd_layer     (cmd_layer),
    .cmd_in_bank   (cmd_in_bank),
    .cmd_out_bank  (cmd_out_bank),
    .cmd_skip_bank (cmd_skip_bank),
    .cmd_skip_use  (cmd_skip_use),
    .cmd_tm_op     (cmd_tm_op),
    .eng_done      (eng_done)
);

// File: tb/tile_seq_tb.sv
module tile_seq_tb;

    typedef struct packed {
        logic [4:0]  layers;
        logic [7:0]  tiles;
        logic [3:0]  cat0;
        logic [3:0]  cat1;
        logic [3:0]  cat2;
        logic [2:0]  en;
        logic [15:0] fork_m;
        logic [15:0] join_m;
        logic [3:0]  lat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{5'd4,  8'd2, 4'd0, 4'd0, 4'd0, 3'b000, 16'h0000, 16'h0000, 4'd0},
        '{5'd12, 8'd1, 4'd0, 4'd0, 4'd0, 3'b000, 16'h0022, 16'h0088, 4'd1},
        '{5'd12, 8'd4, 4'd3, 4'd0, 4'd0, 3'b001, 16'h0002, 16'h0008, 4'd2},
        '{5'd14, 8'd8, 4'd2, 4'd5, 4'd9, 3'b111, 16'h0048, 16'h0120, 4'd0},
        '{5'd1,  8'd3, 4'd0, 4'd0, 4'd0, 3'b000, 16'h0000, 16'h0000, 4'd1},
        '{5'd16, 8'd2, 4'd6, 4'd6, 4'd0, 3'b011, 16'h0011, 16'h1013, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  cfg_layers;
    logic [7:0]  cfg_tiles;
    logic [11:0] cfg_cat_layers;
    logic [2:0]  cfg_cat_en;
    logic [15:0] cfg_fork_mask;
    logic [15:0] cfg_join_mask;
    logic        eng_done;
    logic        busy;
    logic        cmd_valid;
    logic [7:0]  cmd_tile;
    logic [3:0]  cmd_layer;
    logic [1:0]  cmd_in_bank;
    logic [1:0]  cmd_out_bank;
    logic [1:0]  cmd_skip_bank;
    logic        cmd_skip_use;
    logic [1:0]  cmd_tm_op;
    logic [1:0]  cmd_tm_slot;

    always #5 clk = ~clk;

    tile_seq u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_layers(cfg_layers), .cfg_tiles(cfg_tiles),
        .cfg_cat_layers(cfg_cat_layers), .cfg_cat_en(cfg_cat_en),
        .cfg_fork_mask(cfg_fork_mask), .cfg_join_mask(cfg_join_mask),
        .eng_done(eng_done), .busy(busy), .cmd_valid(cmd_valid),
        .cmd_tile(cmd_tile), .cmd_layer(cmd_layer),
        .cmd_in_bank(cmd_in_bank), .cmd_out_bank(cmd_out_bank),
        .cmd_skip_bank(cmd_skip_bank), .cmd_skip_use(cmd_skip_use),
        .cmd_tm_op(cmd_tm_op), .cmd_tm_slot(cmd_tm_slot)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    vec_t cur;
    int   m_layer, m_tile, m_in, m_hold;
    bit   m_act, m_fin;
    bit   m_pend [3];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (tile %0d layer %0d)", tag, act, exp, m_tile, m_layer);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int cat_of(int j);
        return (j == 0) ? int'(cur.cat0) : (j == 1) ? int'(cur.cat1) : int'(cur.cat2);
    endfunction

    function automatic int exp_out();
        for (int k = 0; k < 3; k++)
            if (k != m_in && !(m_act && k == m_hold)) return k;
        return 0;
    endfunction

    task automatic exp_tm(output int op, output int slot);
        op = 0; slot = 0;
        for (int j = 2; j >= 0; j--) begin
            if (cur.en[j] && cat_of(j) == m_layer) begin
                op = m_pend[j] ? 2 : 1;
                slot = j;
            end
        end
    endtask

    task automatic restart_model();
        m_layer = 0; m_in = 0; m_act = 0;
    endtask

    task automatic advance_model();
        int op, slot, o;
        exp_tm(op, slot);
        if (op == 1) begin
            m_pend[slot] = 1;       // R6: store restarts at layer 0 with next tile
            m_tile++;
            restart_model();
        end else if (m_layer == int'(cur.layers) - 1) begin
            if (m_tile >= int'(cur.tiles) - 1) m_fin = 1;
            else begin
                m_tile++;
                restart_model();
                for (int j = 0; j < 3; j++) m_pend[j] = 0;
            end
        end else begin
            if (op == 2) m_pend[slot] = 0;  // R7
            o = exp_out();
            if (cur.join_m[m_layer] && m_act) m_act = 0;
            else if (cur.fork_m[m_layer] && !m_act) begin
                m_act = 1;
                m_hold = m_in;
            end
            m_in = o;
            m_layer++;
        end
    endtask

    task automatic drive_cfg(input vec_t v);
        cfg_layers     = v.layers;
        cfg_tiles      = v.tiles;
        cfg_cat_layers = {v.cat2, v.cat1, v.cat0};
        cfg_cat_en     = v.en;
        cfg_fork_mask  = v.fork_m;
        cfg_join_mask  = v.join_m;
    endtask

    task automatic run_vec(input vec_t v, input bit inject);
        int n, op, slot, su;
        cur = v;
        drive_cfg(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_tile = 0; m_fin = 0; m_hold = 0;
        for (int j = 0; j < 3; j++) m_pend[j] = 0;
        restart_model();
        n = 0;
        while (!m_fin && n < 4000) begin
            chk("R11 busy during run", int'(busy && cmd_valid), 1);
            if (!busy) break;
            chk("R1 R6 R7 layer", int'(cmd_layer), m_layer);
            chk("R1 R6 tile", int'(cmd_tile), m_tile);
            chk("R2 R3 banks", int'(cmd_in_bank) * 4 + int'(cmd_out_bank), m_in * 4 + exp_out());
            su = (cur.join_m[m_layer] && m_act) ? 1 : 0;
            chk("R4 skip use", int'(cmd_skip_use), su);
            if (su == 1) chk("R4 skip bank", int'(cmd_skip_bank), m_hold);
            exp_tm(op, slot);
            chk("R5 R8 tile memory op", int'(cmd_tm_op) * 4 + int'(cmd_tm_slot), op * 4 + slot);
            repeat (int'(v.lat)) @(negedge clk);
            if (v.lat != 0)
                chk("R9 held command", int'(cmd_layer) * 16 + int'(cmd_in_bank), m_layer * 16 + m_in);
            if (inject && n == 4) begin
                // R10: start while busy is rejected
                cfg_layers = 5'd2;
                cfg_tiles  = 8'd1;
                cfg_cat_en = 3'b000;
                start      = 1'b1;
            end
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            start    = 1'b0;
            drive_cfg(v);
            advance_model();
            n++;
        end
        chk("R11 busy low at end", int'(busy), 0);
        chk("R11 model finished", int'(m_fin), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        eng_done = 1'b0;
        drive_cfg(VECS[0]);
        repeat (3) @(negedge clk);
        chk("R12 busy after reset", int'(busy), 0);
        chk("R12 cmd_valid after reset", int'(cmd_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        // R9: done while idle is ignored
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        @(negedge clk);
        chk("R9 idle done busy", int'(busy), 0);
        chk("R9 idle done cmd_valid", int'(cmd_valid), 0);

        // R10: invalid configurations rejected
        cfg_layers = 5'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 zero layers rejected", int'(busy), 0);
        cfg_layers = 5'd17;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 too many layers rejected", int'(busy), 0);
        cfg_layers = 5'd4;
        cfg_tiles = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 zero tiles rejected", int'(busy), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i == 1);
            @(negedge clk);
            chk("R11 idle between runs", int'(cmd_valid), 0);
        end

        summary();
    end

endmodule